// File: doc/BRIEF.md
# Interrupt Enable and Master Control Unit

This unit sits between five interrupt sources of a small microcontroller and its core. The sources are an external pin, a timer, a UART, a capture/frequency unit and an audio decoder. An event pulse from a source sets that source's request flag. Each source also has its own enable bit. One master enable gates all of them. When the master enable is set and at least one enabled flag is pending, the unit raises a request to the core and reports the index of the highest-priority pending source.

When the core takes the interrupt it pulses an acknowledge strobe. In that same clock edge the unit clears the winning source's flag and the master enable, so no second request can be accepted before the handler starts. A return-from-interrupt strobe sets the master enable again. Software can also set it from inside a handler to allow nested interrupts. All enables and flags are held in two 8-bit registers that software can read and write.

Top module: `intc_ctrl`

## Requirements
- R1: After reset, every enable bit, every request flag and the master enable are 0. `irq` is 0, `vec` is 0, and both registers read 0.
- R2: Register 0 (`reg_sel`=0) reads as follows:
  - bit0: master enable
  - bits 3:1: enables for external, timer and UART
  - bits 6:4: flags for external, timer and UART
  - bit7: always 0

  Register 1 (`reg_sel`=1) reads as follows:
  - bits 1:0: enables for capture and audio
  - bits 3:2: flags for capture and audio
  - bits 7:4: always 0
- R3: A one-cycle `src_pulse` bit sets its flag at the next edge, whether or not the source is enabled. Source bit order is 0 external, 1 timer, 2 UART, 3 capture, 4 audio. The flag then stays set until it is cleared.
- R4: `irq` is 1 exactly when the master enable is 1 and at least one flag whose enable is set is pending.
- R5: `vec` gives the lowest-numbered pending enabled source: 0 external, 1 timer, 2 UART, 3 capture, 4 audio. It is 0 when no enabled flag is pending. It does not depend on the master enable.
- R6: `ack` while `irq` is 1 clears, at that edge, both the master enable and the flag of the source named by `vec`. Other flags are kept. If the same source pulses in that same cycle, its flag stays set.
- R7: `reti` sets the master enable at the next edge. If `ack` with `irq` high occurs in the same cycle, the clear wins.
- R8: Writing 1 to register 0 bit0 inside a handler re-enables requests, so a pending lower-priority source raises `irq` again (nesting).
- R9: A register write of 0 to a flag bit clears that flag, and a write of 1 leaves it unchanged. A source pulse in the same cycle as a clearing write leaves the flag set.
- R10: `ack` while `irq` is 0 has no effect on the flags or on the master enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 5 | Event pulses, one bit per source |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select (0 or 1) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ack | input | 1 | Interrupt acknowledge from the core |
| reti | input | 1 | Return-from-interrupt strobe |
| irq | output | 1 | Interrupt request to the core |
| vec | output | VEC_W | Index of the winning source |

## Verification
The assertions take some things for granted about the inputs:
- `ack` is only meaningful while `irq` is high.
- Source pulses are single-cycle events.

For that reason the assertion on acknowledge is conditioned on `irq`, and a same-cycle pulse is treated as an exception to the flag clear. The stimulus drives every strobe for one cycle at a time, on the falling edge. It issues `ack` while `irq` is low only in the directed test for R10, and it overlaps `ack` with `reti`, or a clearing write with a pulse, only in the corner tests that target those races.

// File: rtl/intc_ctrl.sv
module intc_ctrl #(
  parameter int VEC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       src_pulse,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             ack,
  input  logic             reti,
  output logic             irq,
  output logic [VEC_W-1:0] vec
);
  localparam int NSRC = 5;

  logic            me;
  logic [NSRC-1:0] en, flg, pend, win_oh, clr_sw, clr_ack;
  logic [VEC_W-1:0] win_idx;
  logic            take, wr0, wr1;

  assign pend = flg & en;
  assign irq  = me & (|pend);
  assign take = ack & irq;
  assign wr0  = reg_wr & ~reg_sel;
  assign wr1  = reg_wr & reg_sel;
  assign vec  = win_idx;

  always_comb begin
    win_idx = '0;
    win_oh  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        win_idx   = VEC_W'(i);
        win_oh    = '0;
        win_oh[i] = 1'b1;
      end
    end
  end

  assign clr_sw[2:0] = wr0 ? ~reg_wdata[6:4] : 3'b000;
  assign clr_sw[4:3] = wr1 ? ~reg_wdata[3:2] : 2'b00;
  assign clr_ack     = take ? win_oh : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg <= '0;
      en  <= '0;
      me  <= 1'b0;
    end else begin
      flg <= (flg & ~clr_sw & ~clr_ack) | src_pulse;
      if (wr0) en[2:0] <= reg_wdata[3:1];
      if (wr1) en[4:3] <= reg_wdata[1:0];
      if (take)      me <= 1'b0;
      else if (reti) me <= 1'b1;
      else if (wr0)  me <= reg_wdata[0];
    end
  end

  assign reg_rdata = reg_sel ? {4'b0000, flg[4:3], en[4:3]}
                             : {1'b0, flg[2:0], en[2:0], me};
endmodule

// File: rtl/intc_ctrl_chk.sv
module intc_ctrl_chk #(
  parameter int VEC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [4:0]       src_pulse,
  input logic             ack,
  input logic             reti,
  input logic             irq,
  input logic [VEC_W-1:0] vec,
  input logic             me,
  input logic [4:0]       flg,
  input logic [4:0]       pend
);
  // R4
  a_r4_no_irq_without_me: assert property (@(posedge clk) disable iff (!rst_n)
    !me |-> !irq);

  // R3
  a_r3_pulse_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((flg & $past(src_pulse)) == $past(src_pulse)));

  // R5
  a_r5_winner_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != 5'd0) |-> (pend[vec] && ((pend & ((5'd1 << vec) - 5'd1)) == 5'd0)));

  // R6
  a_r6_ack_drops_me: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (!me && !irq));

  // R6
  a_r6_ack_clears_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (!flg[$past(vec)] || $past(src_pulse[vec])));

  // R7
  a_r7_reti_sets_me: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(ack && irq)) |=> me);
endmodule

bind intc_ctrl intc_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .ack(ack), .reti(reti),
  .irq(irq), .vec(vec), .me(me), .flg(flg), .pend(pend)
);

// File: tb/tb_intc_ctrl.sv
`timescale 1ns/1ps
module tb_intc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] src_pulse = '0;
  logic       reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ack = 1'b0, reti = 1'b0;
  logic       irq;
  logic [2:0] vec;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  intc_ctrl dut (.clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack(ack),
    .reti(reti), .irq(irq), .vec(vec));

  // {me, en[4:0], pulse[4:0], exp_irq, exp_vec[2:0]}
  localparam logic [14:0] TBL [9] = '{
    {1'b1, 5'b11111, 5'b00001, 1'b1, 3'd0},
    {1'b1, 5'b11111, 5'b11110, 1'b1, 3'd1},
    {1'b1, 5'b11111, 5'b11100, 1'b1, 3'd2},
    {1'b1, 5'b11111, 5'b11000, 1'b1, 3'd3},
    {1'b1, 5'b11111, 5'b10000, 1'b1, 3'd4},
    {1'b0, 5'b11111, 5'b11111, 1'b0, 3'd0},
    {1'b1, 5'b00000, 5'b11111, 1'b0, 3'd0},
    {1'b1, 5'b10110, 5'b01001, 1'b0, 3'd0},
    {1'b1, 5'b01010, 5'b11111, 1'b1, 3'd1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel = sel; #0.1; d = reg_rdata;
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk); src_pulse = m;
    @(negedge clk); src_pulse = '0;
  endtask

  task automatic strobe(input logic a, input logic r);
    @(negedge clk); ack = a; reti = r;
    @(negedge clk); ack = 1'b0; reti = 1'b0;
  endtask

  task automatic setup(input logic m, input logic [4:0] e);
    wr(1'b0, {1'b0, 3'b000, e[2:0], m});
    wr(1'b1, {4'b0000, 2'b00, e[4:3]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 vec", {5'd0, vec}, 8'h00);
    rd(1'b0, d); chk("R1 reg0", d, 8'h00);
    rd(1'b1, d); chk("R1 reg1", d, 8'h00);

    // R4 R5 table
    for (int i = 0; i < 9; i++) begin
      setup(TBL[i][14], TBL[i][13:9]);
      pulse(TBL[i][8:4]);
      chk("R4 irq", {7'd0, irq}, {7'd0, TBL[i][3]});
      chk("R5 vec", {5'd0, vec}, {5'd0, TBL[i][2:0]});
    end

    // R2 R3 layout and latch while disabled
    setup(1'b1, 5'b00000);
    pulse(5'b11111);
    rd(1'b0, d); chk("R2 R3 reg0 flags", d, 8'h71);
    rd(1'b1, d); chk("R2 R3 reg1 flags", d, 8'h0C);
    wr(1'b1, 8'hFF);
    rd(1'b1, d); chk("R2 reg1 reserved", d, 8'h0F);

    // R9 write 1 keeps, write 0 clears
    wr(1'b0, 8'hFF);
    rd(1'b0, d); chk("R9 keep flags", d, 8'h7F);
    wr(1'b0, 8'h5F);
    rd(1'b0, d); chk("R9 clear timer flag", d, 8'h5F);
    // R9 pulse beats clearing write
    @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h0F; src_pulse = 5'b00100;
    @(negedge clk); reg_wr = 1'b0; src_pulse = '0;
    rd(1'b0, d); chk("R9 race", d, 8'h4F);

    // R6 R8 ack and nesting
    setup(1'b1, 5'b11111);
    pulse(5'b00011);
    chk("R6 pre vec", {5'd0, vec}, 8'h00);
    strobe(1'b1, 1'b0);
    chk("R6 irq low", {7'd0, irq}, 8'h00);
    rd(1'b0, d); chk("R6 winner cleared", d, 8'h2E);
    wr(1'b0, 8'h7F);
    chk("R8 nested irq", {7'd0, irq}, 8'h01);
    chk("R8 nested vec", {5'd0, vec}, 8'h01);
    strobe(1'b1, 1'b0);
    rd(1'b0, d); chk("R6 second ack", d, 8'h0E);
    strobe(1'b0, 1'b1);
    rd(1'b0, d); chk("R7 reti sets me", d, 8'h0F);
    chk("R7 no pending", {7'd0, irq}, 8'h00);

    // R6 pulse of winner in ack cycle keeps flag
    pulse(5'b00010);
    @(negedge clk); ack = 1'b1; src_pulse = 5'b00010;
    @(negedge clk); ack = 1'b0; src_pulse = '0;
    rd(1'b0, d); chk("R6 pulse beats ack", d, 8'h2E);

    // R7 ack beats reti
    wr(1'b0, 8'h2F);
    @(negedge clk); ack = 1'b1; reti = 1'b1;
    @(negedge clk); ack = 1'b0; reti = 1'b0;
    rd(1'b0, d); chk("R7 ack wins", d, 8'h0E);

    // R10 ack while irq low
    setup(1'b0, 5'b11111);
    pulse(5'b00100);
    strobe(1'b1, 1'b0);
    rd(1'b0, d); chk("R10 ack ignored", d, 8'h4E);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule